// File: doc/BRIEF.md
# Peak-Current PWM Speed Controller

This block sets the speed of a fan motor by limiting the peak coil current in each cycle of a fixed-frequency PWM. It receives digitized codes for the speed command, the lowest allowed speed, the sensed coil current and a rising soft-start ramp. From these it produces one drive-enable bit that gates the commutation pattern of the output bridge. All codes share one scale: a full-scale code of the converter width stands for the regulator voltage.

A period starts with the drive on. The drive turns off as soon as the sensed current reaches the target. It stays off until the next period begins. The target rises as the command falls below a reference level, with a gain of one eighth. A command above the reference stops the motor. Three limits bound the target: a fixed current ceiling, a ceiling equal to one tenth of the soft-start ramp (which applies until the ramp reaches its end level), and a lowest-speed input that the effective command can never exceed. The target is taken only at a period boundary, so a change to any input in mid-period does not move the turn-off point.

Top module: `pwm_cur_ctl`

## Requirements
- R1: The period is `PERIOD` clocks long. The drive can switch on only at the clock edge that starts a period. A period starts at the first edge after reset release and again every `PERIOD` edges after that.
- R2: Once the drive is off inside a period, it stays off until the next period start.
- R3: The effective command `e` is used to form the target as `(REF_CODE - e) >> 3`, in sense-code units.
- R4: When `ctl_code > REF_CODE` at a period start, the drive stays off for that whole period, whatever the lowest-speed input is.
- R5: The target never exceeds `LIM_CODE`.
- R6: The effective command is `min(ctl_code, minsp_code)`.
- R7: While `ramp_code < SS_END_CODE`, the target is also capped at `ramp_code / 10` (integer division). At or above `SS_END_CODE`, the ramp imposes no cap.
- R8: The target and the stop decision are sampled only at a period start. Input changes within a period do not alter that period's drive.
- R9: If the sense code is already at or above the target at a period start, the drive gives no pulse in that period. During the period, the drive turns off at the first edge where the sense code is at or above the target.
- R10: While `rst_n` is low, `drive_en` is 0. The first edge after release begins a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_code | input | DW | Speed command code; lower means faster |
| minsp_code | input | DW | Lowest-speed setting; the effective command is capped at this level |
| ramp_code | input | DW | Soft-start ramp level |
| isns_code | input | DW | Sensed coil current code |
| drive_en | output | 1 | Bridge enable for the current commutation step |

## Verification
The hardest case to reach is the turn-off edge inside a period, because it depends on a sense value that moves while the drive is on. The bench raises the sense code by one per clock from zero. It then checks that the drive falls at exactly the clock where the code meets a target that the bench has worked out in advance. One run sets that target through the command and another through the soft-start ceiling. A second difficult case is a command that moves in mid-period. The bench changes the command to a stop level halfway through a period and checks that the drive holds until the boundary and drops only in the next period.

// File: rtl/pwm_ctl_pkg.sv
// Shared constants of the current control law.
// Assumes all analogue quantities arrive as codes on one common scale.
package pwm_ctl_pkg;
    // Gain from command headroom to current target is 1/8 (right shift).
    localparam int unsigned TGT_SHIFT = 3;
    // Soft-start ceiling is the ramp code divided by this factor.
    localparam int unsigned SS_DIV    = 10;
endpackage

// File: rtl/pwm_period_timer.sv
// Free-running period counter; flags the first clock of each PWM period.
// Assumes PERIOD >= 2. After reset the counter sits at zero, so the first
// edge after reset release begins a period.
module pwm_period_timer #(
    parameter int unsigned PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_start
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within a period and wrap at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign period_start = (cnt_q == '0);
endmodule

// File: rtl/pwm_target_calc.sv
// Combinational current-target law: command headroom below the reference,
// scaled by 1/8, then capped by the fixed limit and by the soft-start ceiling.
// Assumes all inputs are codes on a common scale. The stop decision uses the
// raw command, so the lowest-speed input cannot prevent a stop.
module pwm_target_calc
    import pwm_ctl_pkg::*;
#(
    parameter int unsigned DW          = 10,
    parameter int unsigned REF_CODE    = 614,
    parameter int unsigned LIM_CODE    = 51,
    parameter int unsigned SS_END_CODE = 512
) (
    input  logic [DW-1:0] ctl_code,
    input  logic [DW-1:0] minsp_code,
    input  logic [DW-1:0] ramp_code,
    output logic [DW-1:0] tgt,
    output logic          stop
);
    localparam logic [DW-1:0] REF_C = DW'(REF_CODE);
    localparam logic [DW-1:0] LIM_C = DW'(LIM_CODE);
    localparam logic [DW-1:0] SSE_C = DW'(SS_END_CODE);

    logic [DW-1:0] eff, head, law, capped, ss_cap;

    // Effective command: never above the lowest-speed setting.
    always_comb eff = (ctl_code < minsp_code) ? ctl_code : minsp_code;

    // Headroom below the reference, then the 1/8 gain.
    always_comb begin
        head = (eff <= REF_C) ? (REF_C - eff) : '0;
        law  = head >> TGT_SHIFT;
    end

    // Apply the fixed limit and, during soft start, the ramp ceiling.
    always_comb begin
        ss_cap = ramp_code / DW'(SS_DIV);
        capped = (law > LIM_C) ? LIM_C : law;
        if (ramp_code < SSE_C && ss_cap < capped) capped = ss_cap;
    end

    assign stop = (ctl_code > REF_C);
    assign tgt  = stop ? '0 : capped;
endmodule

// File: rtl/pwm_drive_latch.sv
// Per-period drive flop: sets at period start when the sense code is below
// the freshly sampled target, and clears when the sense code reaches the
// held target. Assumes tgt_in/stop_in are settled at period start.
module pwm_drive_latch #(
    parameter int unsigned DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_start,
    input  logic [DW-1:0] tgt_in,
    input  logic          stop_in,
    input  logic [DW-1:0] isns_code,
    output logic          drive_q,
    output logic [DW-1:0] tgt_q
);
    // Hold the target for the whole period; reload only at its start.
    always_ff @(posedge clk) begin
        if (!rst_n)            tgt_q <= '0;
        else if (period_start) tgt_q <= tgt_in;
    end

    // Set at period start, clear on peak current, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                     drive_q <= 1'b0;
        else if (period_start)          drive_q <= !stop_in && (isns_code < tgt_in);
        else if (isns_code >= tgt_q)    drive_q <= 1'b0;
    end
endmodule

// File: rtl/pwm_cur_ctl.sv
// Peak-current PWM speed controller top. Joins the period timer, the target
// law and the drive flop. Assumes a clock of PERIOD times the PWM rate and
// converter codes that are synchronous to clk.
module pwm_cur_ctl #(
    parameter int unsigned DW          = 10,
    parameter int unsigned PERIOD      = 1000,
    parameter int unsigned REF_CODE    = 614,
    parameter int unsigned LIM_CODE    = 51,
    parameter int unsigned SS_END_CODE = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ctl_code,
    input  logic [DW-1:0] minsp_code,
    input  logic [DW-1:0] ramp_code,
    input  logic [DW-1:0] isns_code,
    output logic          drive_en
);
    logic          period_start;
    logic [DW-1:0] tgt_next, tgt_q;
    logic          stop_next;

    pwm_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .period_start(period_start)
    );

    pwm_target_calc #(
        .DW(DW), .REF_CODE(REF_CODE), .LIM_CODE(LIM_CODE), .SS_END_CODE(SS_END_CODE)
    ) u_law (
        .ctl_code(ctl_code), .minsp_code(minsp_code), .ramp_code(ramp_code),
        .tgt(tgt_next), .stop(stop_next)
    );

    pwm_drive_latch #(.DW(DW)) u_drv (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .tgt_in(tgt_next), .stop_in(stop_next), .isns_code(isns_code),
        .drive_q(drive_en), .tgt_q(tgt_q)
    );
endmodule

// File: rtl/pwm_cur_ctl_chk.sv
// Property checker for pwm_cur_ctl, attached by bind.
module pwm_cur_ctl_chk #(
    parameter int unsigned DW       = 10,
    parameter int unsigned REF_CODE = 614,
    parameter int unsigned LIM_CODE = 51
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] ctl_code,
    input logic [DW-1:0] isns_code,
    input logic          drive_en,
    input logic          period_start,
    input logic [DW-1:0] tgt_q
);
    localparam logic [DW-1:0] REF_C = DW'(REF_CODE);
    localparam logic [DW-1:0] LIM_C = DW'(LIM_CODE);

    // R1
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> $past(period_start));

    // R2
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en && !period_start) |=> !drive_en);

    // R4
    stop_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && ctl_code > REF_C) |=> !drive_en);

    // R5
    limit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && isns_code >= LIM_C) |=> !drive_en);

    // R8
    target_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(tgt_q));
endmodule

bind pwm_cur_ctl pwm_cur_ctl_chk #(
    .DW(DW), .REF_CODE(REF_CODE), .LIM_CODE(LIM_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_code(ctl_code), .isns_code(isns_code),
    .drive_en(drive_en), .period_start(period_start), .tgt_q(tgt_q)
);

// File: tb/sim_pwm_cur_ctl.sv
module sim_pwm_cur_ctl;
    localparam int CLK_P  = 10;
    localparam int DW     = 10;
    localparam int PER    = 32;
    localparam int REF    = 614;
    localparam int LIM    = 51;
    localparam int SS_END = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] ctl = '0, msp = '0, rmp = '0, isn = '0;
    logic          drv;
    int            checks = 0, failures = 0;

    always #(CLK_P/2) clk = ~clk;

    pwm_cur_ctl #(.DW(DW), .PERIOD(PER), .REF_CODE(REF), .LIM_CODE(LIM),
                  .SS_END_CODE(SS_END)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_code(ctl), .minsp_code(msp),
        .ramp_code(rmp), .isns_code(isn), .drive_en(drv));

    // Target from the requirements; -1 means stopped (R4).
    function automatic int exp_tgt(int c, int m, int r);
        int e, t;
        if (c > REF) return -1;
        e = (c < m) ? c : m;            // R6
        t = (REF - e) / 8;              // R3
        if (t > LIM) t = LIM;           // R5
        if (r < SS_END && r / 10 < t) t = r / 10; // R7
        return t;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s drive_en actual=%0b expected=%0b (ctl=%0d msp=%0d rmp=%0d isn=%0d)",
                     req, act, exp, ctl, msp, rmp, isn);
        end
    endtask

    // Call at the negedge before a period start; returns at the negedge before the next.
    task automatic run_period(input int c, input int m, input int r, input int s, input string req);
        int t = exp_tgt(c, m, r);
        logic e = (t >= 0) && (s < t);
        ctl = DW'(c); msp = DW'(m); rmp = DW'(r); isn = DW'(s);
        for (int i = 0; i < PER; i++) begin
            @(posedge clk); @(negedge clk);
            if (i == 0 || i == PER/2 || i == PER-1) chk(req, drv, e);
        end
    endtask

    // Sense code climbs by one per clock from zero; drive must fall at edge t (R9, R2).
    task automatic run_ramp(input int c, input int m, input int r, input string req);
        int t = exp_tgt(c, m, r);
        ctl = DW'(c); msp = DW'(m); rmp = DW'(r); isn = '0;
        for (int i = 0; i < PER; i++) begin
            @(posedge clk); @(negedge clk);
            chk(req, drv, logic'(i < t));
            isn = DW'(i + 1);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cv[6] = '{0, 205, 400, 574, 614, 615};
        int mv[3] = '{1023, 300, 614};
        int rv[5] = '{0, 55, 300, 512, 1023};
        // R10: reset holds drive low even with a fast command and zero sense.
        ctl = '0; msp = '1; rmp = '1; isn = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", drv, 1'b0);
        rst_n = 1'b1;   // next posedge starts a period

        // R1/R10: first period after reset drives at full limit.
        run_period(0, 1023, 1023, 0, "R1");

        // Sweep of command, lowest speed and ramp, with sense around the target.
        foreach (cv[a]) foreach (mv[b]) foreach (rv[d]) begin
            int t = exp_tgt(cv[a], mv[b], rv[d]);
            string req;
            if (t < 0)                               req = "R4";
            else if (rv[d] < SS_END && rv[d]/10 < LIM) req = "R7";
            else if (mv[b] < cv[a])                  req = "R6";
            else if (t == LIM)                       req = "R5";
            else                                     req = "R3";
            if (t < 0) begin
                run_period(cv[a], mv[b], rv[d], 0, req);
            end else begin
                run_period(cv[a], mv[b], rv[d], (t > 0) ? t - 1 : 0, req);
                run_period(cv[a], mv[b], rv[d], t, {req, "_R9"});
            end
        end

        // R9/R2: turn-off edge set by the command law (target 5).
        run_ramp(574, 1023, 1023, "R9");
        // R7/R2: turn-off edge set by the soft-start ceiling (target 10).
        run_ramp(0, 1023, 100, "R7");

        // R8: command jumps to stop level mid-period; drive holds to the boundary.
        ctl = DW'(205); msp = '1; rmp = '1; isn = '0;
        for (int i = 0; i < PER; i++) begin
            @(posedge clk); @(negedge clk);
            if (i == PER/2) ctl = DW'(1023);
            if (i == PER-1) chk("R8", drv, 1'b1);
        end
        @(posedge clk); @(negedge clk);
        chk("R8", drv, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule